// File: doc/BRIEF.md
# Frame Base Latch and Interrupt Unit

This block is the register-side control slice of a raster display controller. Software writes the address of the next frame buffer through a small register port. The block holds that value as pending and passes it to the pixel fetch engine only when the video timing reports the start of a frame. A tear-free page flip therefore needs only one register write followed by waiting for the update interrupt. The pixel fetch engine and the timing generator sit outside this block; the timing generator provides a one-cycle `frame_start` strobe.

The block also keeps the interrupt state. There is one raw status bit per source, a mask register, a masked view and a write-one-to-clear register, and the single `irq` line is the OR of the masked bits. A panel sequencer turns one software on/off request into two outputs, `panel_en` and `panel_pwr`. These outputs always switch in a safe order, with a programmable settle time between them, so the display supply can stabilise before the panel is driven.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current state, and there is no back-pressure. Register indices (on `reg_addr`): 0 pending base, 1 active base (read only), 2 panel request (bit 0), 3 interrupt mask, 4 raw status (read only), 5 masked status (read only), 6 clear (write only, reads 0), 7 panel status (read only). Interrupt bit 0 is "base taken up", and interrupt bit 1 is "frame started".

Top module: `fb_base_irq_ctrl`

## Requirements
- R1: After reset, `fetch_base`, the pending base, the mask, the raw status, `panel_en`, `panel_pwr` and `irq` are all zero, and no pending base is waiting.
- R2: A write to index 0 stores a pending base whose two low bits read back as zero. `fetch_base` keeps its value until a later frame start.
- R3: On a `frame_start` cycle with a pending base waiting, `fetch_base` shows that base from the next cycle, and raw bit 0 sets at the same edge. A `frame_start` with nothing waiting leaves `fetch_base` and raw bit 0 unchanged.
- R4: If a base write and `frame_start` occur in the same cycle, the previously waiting base (if any) is taken up, and the newly written value stays pending for the next frame start.
- R5: Raw bit 1 sets at the edge of every `frame_start` cycle.
- R6: Index 5 reads raw status AND mask (index 3). `irq` is high exactly when that value is non-zero.
- R7: Writing ones to index 6 clears those raw bits. When a source sets a bit in the same cycle as it is cleared, the bit ends set.
- R8: When the panel request (index 2 bit 0) turns on, `panel_en` rises one cycle after the request register changes. `panel_pwr` rises exactly SETTLE_CYC cycles after `panel_en`.
- R9: When the request turns off, `panel_pwr` falls one cycle after the request register changes. `panel_en` falls exactly SETTLE_CYC cycles after `panel_pwr`.
- R10: A settle period always runs to its end. If the request is withdrawn during power-up, `panel_pwr` never rises and `panel_en` falls when the period ends. If the request is raised during power-down, `panel_en` falls at the end of the period and rises again one cycle later.
- R11: Index 7 reads bit 0 = `panel_en`, bit 1 = `panel_pwr`, bit 2 = a pending base is waiting. Index 2 reads back the request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for `reg_addr` |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| fetch_base | output | ADDR_W | Active frame base for the fetch engine |
| panel_en | output | 1 | Controller enable toward the panel |
| panel_pwr | output | 1 | Panel power output |
| irq | output | 1 | Interrupt request |

## Verification
The bench instantiates the block with ADDR_W = 32 and BUS_W = 32, so random base addresses use the full word, including the low two bits that must be dropped. SETTLE_CYC is reduced to 8 from the millisecond-scale default. With that value, a complete power-up, a complete power-down, and both mid-settle reversals each fit in a few dozen cycles, and the exact rise and fall cycle of each output can be checked against the counted settle time.

// File: rtl/fbl_pkg.sv
package fbl_pkg;

  typedef enum logic [2:0] {
    RG_PEND  = 3'd0,
    RG_ACT   = 3'd1,
    RG_PANEL = 3'd2,
    RG_IMASK = 3'd3,
    RG_IRAW  = 3'd4,
    RG_IMSK  = 3'd5,
    RG_ICLR  = 3'd6,
    RG_STAT  = 3'd7
  } reg_idx_e;

  localparam int NUM_IRQ   = 2;
  localparam int IRQ_BASE  = 0;
  localparam int IRQ_FRAME = 1;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_UP   = 2'd1,
    PS_ON   = 2'd2,
    PS_DOWN = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/fbl_base_latch.sv
module fbl_base_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-3:0] wr_word,
  input  logic              frame_start,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [ADDR_W-1:0] act_addr,
  output logic              pend_vld,
  output logic              taken
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] act_q;
  logic              vld_q;

  // the waiting base is consumed exactly on a frame boundary
  assign taken = frame_start & vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (taken)
        act_q <= pend_q;
      // a write in the boundary cycle stays pending for the next frame
      if (wr_en) begin
        pend_q <= wr_word;
        vld_q  <= 1'b1;
      end else if (frame_start) begin
        vld_q  <= 1'b0;
      end
    end
  end

  assign pend_addr = {pend_q, 2'b00};
  assign act_addr  = {act_q, 2'b00};
  assign pend_vld  = vld_q;

  a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_addr));

  a_r3_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_vld) |=> (act_addr == $past(pend_addr)));

  a_r4_write_survives_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && frame_start) |=> pend_vld);

endmodule

// File: rtl/fbl_irq_bank.sv
module fbl_irq_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);

  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (mask_we)
      mask_q <= mask_bits;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic bit_q;
    logic clr_hit;

    assign clr_hit = clr_we & clr_bits[i];

    // a fresh event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (set_i[i])
        bit_q <= 1'b1;
      else if (clr_hit)
        bit_q <= 1'b0;
    end

    assign raw_o[i] = bit_q;

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> raw_o[i]);

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !set_i[i]) |=> !raw_o[i]);
  end

  assign mask_o = mask_q;
  assign pend_o = raw_o & mask_q;
  assign irq_o  = |pend_o;

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw_o & mask_o) != '0));

endmodule

// File: rtl/fbl_panel_seq.sv
module fbl_panel_seq
  import fbl_pkg::*;
#(
  parameter int SETTLE_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_we,
  input  logic req_bit,
  output logic req_o,
  output logic en_o,
  output logic pwr_o
);

  localparam int             CNT_W  = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

  pwr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      req_q <= 1'b0;
    else if (req_we)
      req_q <= req_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PS_OFF: if (req_q) begin
          state_q <= PS_UP;
          cnt_q   <= RELOAD;
        end
        PS_UP: if (cnt_q == '0)
          state_q <= req_q ? PS_ON : PS_OFF;
        else
          cnt_q <= cnt_q - 1'b1;
        PS_ON: if (!req_q) begin
          state_q <= PS_DOWN;
          cnt_q   <= RELOAD;
        end
        PS_DOWN: if (cnt_q == '0)
          state_q <= PS_OFF;
        else
          cnt_q <= cnt_q - 1'b1;
        default: state_q <= PS_OFF;
      endcase
    end
  end

  assign req_o = req_q;
  assign en_o  = (state_q != PS_OFF);
  assign pwr_o = (state_q == PS_ON);

  a_r8_power_under_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_o |-> en_o);

  a_r8_power_rise_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_o) |-> $past(en_o));

  a_r9_enable_fall_after_power: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o) |-> (!pwr_o && !$past(pwr_o)));

  a_r10_abort_keeps_power_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_UP && cnt_q == '0 && !req_q) |=> (!pwr_o && !en_o));

endmodule

// File: rtl/fb_base_irq_ctrl.sv
module fb_base_irq_ctrl
  import fbl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_W      = 32,
  parameter int SETTLE_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              frame_start,
  output logic [ADDR_W-1:0] fetch_base,
  output logic              panel_en,
  output logic              panel_pwr,
  output logic              irq
);

  reg_idx_e idx;
  assign idx = reg_idx_e'(reg_addr);

  logic we_pend, we_panel, we_mask, we_clr;
  assign we_pend  = reg_wr && (idx == RG_PEND);
  assign we_panel = reg_wr && (idx == RG_PANEL);
  assign we_mask  = reg_wr && (idx == RG_IMASK);
  assign we_clr   = reg_wr && (idx == RG_ICLR);

  logic [ADDR_W-1:0]  pend_addr;
  logic               pend_vld;
  logic               base_taken;
  logic [NUM_IRQ-1:0] irq_set, irq_raw, irq_mask, irq_pend;
  logic               panel_req;

  fbl_base_latch #(.ADDR_W(ADDR_W)) u_base (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (we_pend),
    .wr_word     (reg_wdata[ADDR_W-1:2]),
    .frame_start (frame_start),
    .pend_addr   (pend_addr),
    .act_addr    (fetch_base),
    .pend_vld    (pend_vld),
    .taken       (base_taken)
  );

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_BASE]  = base_taken;
    irq_set[IRQ_FRAME] = frame_start;
  end

  fbl_irq_bank #(.N(NUM_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (irq_set),
    .clr_we    (we_clr),
    .clr_bits  (reg_wdata[NUM_IRQ-1:0]),
    .mask_we   (we_mask),
    .mask_bits (reg_wdata[NUM_IRQ-1:0]),
    .raw_o     (irq_raw),
    .mask_o    (irq_mask),
    .pend_o    (irq_pend),
    .irq_o     (irq)
  );

  fbl_panel_seq #(.SETTLE_CYC(SETTLE_CYC)) u_panel (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_we  (we_panel),
    .req_bit (reg_wdata[0]),
    .req_o   (panel_req),
    .en_o    (panel_en),
    .pwr_o   (panel_pwr)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (idx)
      RG_PEND:  reg_rdata = BUS_W'(pend_addr);
      RG_ACT:   reg_rdata = BUS_W'(fetch_base);
      RG_PANEL: reg_rdata = BUS_W'(panel_req);
      RG_IMASK: reg_rdata = BUS_W'(irq_mask);
      RG_IRAW:  reg_rdata = BUS_W'(irq_raw);
      RG_IMSK:  reg_rdata = BUS_W'(irq_pend);
      RG_ICLR:  reg_rdata = '0;
      RG_STAT:  reg_rdata = BUS_W'({pend_vld, panel_pwr, panel_en});
      default:  reg_rdata = '0;
    endcase
  end

  a_r5_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> irq_raw[IRQ_FRAME]);

  a_r3_take_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_vld) |=> irq_raw[IRQ_BASE]);

endmodule

// File: tb/fb_base_irq_ctrl_bench.sv
`timescale 1ns/1ps
module fb_base_irq_ctrl_bench;
  import fbl_pkg::*;

  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        frame_start;
  logic [31:0] fetch_base;
  logic        panel_en, panel_pwr, irq;

  always #10 clk = ~clk;

  fb_base_irq_ctrl #(.ADDR_W(32), .BUS_W(32), .SETTLE_CYC(SETTLE)) u_fb_base_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .fetch_base(fetch_base), .panel_en(panel_en), .panel_pwr(panel_pwr), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pend = '0, m_act = '0;
  logic        m_pv = 1'b0, m_req = 1'b0;
  logic [1:0]  m_raw = '0, m_mask = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_pend;
      3'd1: return m_act;
      3'd2: return {31'b0, m_req};
      3'd3: return {30'b0, m_mask};
      3'd4: return {30'b0, m_raw};
      3'd5: return {30'b0, m_raw & m_mask};
      3'd7: return {29'b0, m_pv, 2'b00};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R7";
      3'd2, 3'd7: return "R11";
      default: return "R6";
    endcase
  endfunction

  task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d,
                     input bit fs, input bit chk);
    logic [1:0]  nset, nclr;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; frame_start = fs;
    #1;
    if (chk) begin
      check(tag_of(a), "rdata", reg_rdata, exp_rdata(a));
      check("R3", "fetch_base", fetch_base, m_act);
      check("R6", "irq", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
    end
    @(posedge clk);
    nset = {fs, fs & m_pv};
    nclr = (wr && a == 3'd6) ? d[1:0] : 2'b00;
    m_raw = nset | (m_raw & ~nclr);
    if (fs && m_pv) m_act = m_pend;
    if (wr && a == 3'd0) begin m_pend = {d[31:2], 2'b00}; m_pv = 1'b1; end
    else if (fs) m_pv = 1'b0;
    if (wr && a == 3'd3) m_mask = d[1:0];
    if (wr && a == 3'd2) m_req = d[0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'd7, 32'h0, 0, 0);
  endtask

  task automatic panel_chk(string req, logic en, logic pwr);
    #2;
    check(req, "panel_en", {31'b0, panel_en}, {31'b0, en});
    check(req, "panel_pwr", {31'b0, panel_pwr}, {31'b0, pwr});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; frame_start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1", "fetch_base", fetch_base, 32'h0);
    check("R1", "panel_en", {31'b0, panel_en}, 32'h0);
    check("R1", "panel_pwr", {31'b0, panel_pwr}, 32'h0);
    check("R1", "irq", {31'b0, irq}, 32'h0);
    cyc(0, RG_IRAW, 0, 0, 1);
    cyc(0, RG_STAT, 0, 0, 1);
    cyc(0, RG_PEND, 0, 0, 1);

    // R2: pending base, low bits dropped, active unchanged
    cyc(1, RG_PEND, 32'h1234_5677, 0, 1);
    cyc(0, RG_PEND, 0, 0, 1);
    #2 check("R2", "pending readback", reg_rdata, 32'h1234_5674);
    check("R2", "fetch_base held", fetch_base, 32'h0);

    // R3/R5: take-up on frame start
    cyc(1, RG_IMASK, 32'h3, 0, 1);
    cyc(0, RG_IRAW, 0, 1, 1);
    #2 check("R3", "fetch_base taken", fetch_base, 32'h1234_5674);
    check("R5", "raw after boundary", reg_rdata, 32'h3);
    check("R6", "irq asserted", {31'b0, irq}, 32'h1);

    // R7: clear both
    cyc(1, RG_ICLR, 32'h3, 0, 1);
    cyc(0, RG_IRAW, 0, 0, 1);
    #2 check("R7", "raw cleared", reg_rdata, 32'h0);

    // R3: boundary without a new base
    cyc(0, RG_IRAW, 0, 1, 1);
    #2 check("R3", "only frame flag", reg_rdata, 32'h2);
    check("R3", "fetch_base unchanged", fetch_base, 32'h1234_5674);

    // R7: set and clear in one cycle
    cyc(1, RG_ICLR, 32'h2, 1, 1);
    cyc(0, RG_IRAW, 0, 0, 1);
    #2 check("R7", "set beats clear", reg_rdata, 32'h2);

    // R6: masked view follows mask
    cyc(1, RG_IMASK, 32'h1, 0, 1);
    cyc(0, RG_IMSK, 0, 0, 1);
    #2 check("R6", "masked read", reg_rdata, 32'h0);
    check("R6", "irq masked off", {31'b0, irq}, 32'h0);

    // R4: write in the boundary cycle
    cyc(1, RG_PEND, 32'hAAAA_0000, 0, 1);
    cyc(1, RG_PEND, 32'h5555_1110, 1, 1);
    cyc(0, RG_STAT, 0, 0, 1);
    #2 check("R4", "old pending taken", fetch_base, 32'hAAAA_0000);
    check("R4", "new still waiting", reg_rdata, 32'h4);
    cyc(0, RG_ACT, 0, 1, 1);
    #2 check("R4", "new taken next frame", reg_rdata, 32'h5555_1110);

    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      bit          wr, fs;
      logic [2:0]  a;
      wr = ($urandom % 16) < 5;
      if (wr) begin
        case ($urandom % 3)
          0: a = RG_PEND;
          1: a = RG_IMASK;
          default: a = RG_ICLR;
        endcase
      end else begin
        a = 3'($urandom % 8);
      end
      fs = ($urandom % 5) == 0;
      cyc(wr, a, $urandom, fs, 1);
    end
    cyc(0, RG_IRAW, 0, 0, 1);

    // R8: power-up order and spacing
    cyc(1, RG_PANEL, 32'h1, 0, 0);
    idle(1);
    panel_chk("R8", 1'b1, 1'b0);
    idle(SETTLE - 1);
    panel_chk("R8", 1'b1, 1'b0);
    idle(1);
    panel_chk("R8", 1'b1, 1'b1);
    cyc(0, RG_STAT, 0, 0, 0);
    #2 check("R11", "status on", reg_rdata & 32'h3, 32'h3);
    cyc(0, RG_PANEL, 0, 0, 0);
    #2 check("R11", "request readback", reg_rdata, 32'h1);

    // R9: power-down order and spacing
    cyc(1, RG_PANEL, 32'h0, 0, 0);
    idle(1);
    panel_chk("R9", 1'b1, 1'b0);
    idle(SETTLE - 1);
    panel_chk("R9", 1'b1, 1'b0);
    idle(1);
    panel_chk("R9", 1'b0, 1'b0);

    // R10: withdraw during power-up
    cyc(1, RG_PANEL, 32'h1, 0, 0);
    idle(1);
    panel_chk("R10", 1'b1, 1'b0);
    cyc(1, RG_PANEL, 32'h0, 0, 0);
    idle(SETTLE - 2);
    panel_chk("R10", 1'b1, 1'b0);
    idle(1);
    panel_chk("R10", 1'b0, 1'b0);
    idle(2);
    panel_chk("R10", 1'b0, 1'b0);

    // R10: raise during power-down
    cyc(1, RG_PANEL, 32'h1, 0, 0);
    idle(1 + SETTLE);
    panel_chk("R10", 1'b1, 1'b1);
    cyc(1, RG_PANEL, 32'h0, 0, 0);
    idle(1);
    panel_chk("R10", 1'b1, 1'b0);
    cyc(1, RG_PANEL, 32'h1, 0, 0);
    idle(SETTLE - 2);
    panel_chk("R10", 1'b1, 1'b0);
    idle(1);
    panel_chk("R10", 1'b0, 1'b0);
    idle(1);
    panel_chk("R10", 1'b1, 1'b0);

    finish_run();
  end

endmodule